// File: doc/BRIEF.md
# Transmit Completion Queue Writer

This block sits next to a multi-channel transmit DMA engine and turns its buffer-completion events into 32-bit completion records. The records go into a small queue that the host drains. Each channel has a reporting-granularity bit:

- With the bit clear, the channel reports once per whole packet. The record points back at the packet's first descriptor.
- With the bit set, the channel reports after every buffer, and the status code tells the first, middle and last buffers apart.

An event flagged as an error always produces a record with an error status. The same event raises two one-cycle requests, both naming the channel:

- an abort request to the serial framer;
- a request to clear that channel's enable bit in the per-channel configuration store.

Events enter on a valid/ready port. `evt_ready` is low while a flush is requested. It is also low while the queue is enabled and full, and is high otherwise. An event that is not accepted must be held, unchanged, by the DMA engine until it is accepted, so no completion is ever lost. Records leave on a valid/ready port. `rec_data` holds the oldest record and stays unchanged while `rec_valid` is high and `rec_ready` is low.

Top module: `txdq_writer`

## Requirements
- R1: Record layout:
  - bits 15:0 hold the descriptor offset;
  - bits 23:16 hold the event's channel field (channel number minus one);
  - bits 25:24 are zero;
  - bits 28:26 hold the status;
  - bits 31:29 are zero.
- R2: With the channel's mode bit at 0, a non-error event writes a record only when it marks the last buffer. The status is 000. The offset is the one carried by the most recent first-buffer event on that channel, or the event's own offset when it is both first and last.
- R3: With the mode bit at 1, every non-error event writes a record carrying its own offset. The status is 001 for a first buffer (including a first-and-last buffer), 011 for a last buffer and 010 otherwise.
- R4: An accepted error event writes a record with status {1, evt_err_kind}. In the following cycle it pulses `srl_abort_req` and `cfg_clr_en` for one cycle, with the event's channel on `srl_abort_chan` and `cfg_clr_chan`.
- R5: In mode 0, an error record carries the offset of the packet's first descriptor: the stored one, or the event's own offset when it is a first buffer. In mode 1, an error record carries the event's own offset.
- R6: When the queue holds DEPTH (16) entries and is enabled, `evt_ready` is low and no record is dropped or overwritten. Records leave in arrival order.
- R7: `q_flush` empties the queue at the next edge. While it is high, `evt_ready` is low.
- R8: `q_thresh_hit` is high exactly when the queued count is at least `q_thresh` + 1.
- R9: With `q_enable` low, events are accepted and write no record, and error events still raise the abort and disable requests.
- R10: While `rec_valid` is high and `rec_ready` is low, `rec_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Completion event offered |
| evt_ready | output | 1 | Completion event taken at this edge |
| evt_chan | input | CHW | Channel number minus one |
| evt_offset | input | 16 | Descriptor offset of the finished buffer |
| evt_first | input | 1 | Buffer is the first of its packet |
| evt_last | input | 1 | Buffer is the last of its packet |
| evt_err | input | 1 | Transmission ended in error |
| evt_err_kind | input | 2 | Error type, becomes status bits 1:0 |
| chan_mode | input | 2**CHW | Per-channel mode: 0 per packet, 1 per buffer |
| q_enable | input | 1 | Queue accepts records |
| q_flush | input | 1 | Empty the queue |
| q_thresh | input | THW | Fill-level threshold setting |
| rec_valid | output | 1 | Queue holds a record |
| rec_ready | input | 1 | Host takes the head record |
| rec_data | output | 32 | Head record |
| q_thresh_hit | output | 1 | Fill level reached threshold + 1 |
| srl_abort_req | output | 1 | Abort request pulse to the framer |
| srl_abort_chan | output | CHW | Channel to abort |
| cfg_clr_en | output | 1 | Clear-channel-enable pulse |
| cfg_clr_chan | output | CHW | Channel to take out of service |

## Verification
Some internal faults show up at the ports on the very next record:

- A corrupted per-channel first-offset entry gives a per-packet record with the wrong offset.
- A wrong mode lookup gives a per-packet record with a per-buffer status, or the reverse.

Queue faults take a little longer to appear:

- A wrong fill count shows on `q_thresh_hit` in the cycle after the push or pop that causes it.
- A full-queue fault shows as `evt_ready` staying high, and then as a missing or out-of-order record once the host drains the queue.

A lost error side-effect appears one cycle after the error event is accepted, as a missing abort or disable pulse.

// File: rtl/txdq_pkg.sv
package txdq_pkg;
  localparam int OFFW = 16;

  localparam logic [2:0] ST_PACKET = 3'b000;
  localparam logic [2:0] ST_FIRST  = 3'b001;
  localparam logic [2:0] ST_MIDDLE = 3'b010;
  localparam logic [2:0] ST_LAST   = 3'b011;

  typedef struct packed {
    logic [2:0]      spare;
    logic [2:0]      status;
    logic            rst_bit;
    logic            pri_bit;
    logic [7:0]      chan;
    logic [OFFW-1:0] offset;
  } txdq_rec_t;
endpackage

// File: rtl/txdq_rec_builder.sv
module txdq_rec_builder
  import txdq_pkg::*;
#(
  parameter int CHW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc,
  input  logic [CHW-1:0]       chan,
  input  logic [OFFW-1:0]      offset,
  input  logic                 first,
  input  logic                 last,
  input  logic                 err,
  input  logic [1:0]           err_kind,
  input  logic [(1<<CHW)-1:0]  chan_mode,
  output logic                 rec_want,
  output txdq_rec_t            rec_word
);
  localparam int NCHAN = 1 << CHW;

  logic [OFFW-1:0] first_off [NCHAN];
  logic            mode;
  logic [OFFW-1:0] pkt_off;
  logic [2:0]      status;

  always_ff @(posedge clk) begin
    if (acc && first) first_off[chan] <= offset;
  end

  always_comb begin
    mode    = chan_mode[chan];
    pkt_off = first ? offset : first_off[chan];
    if (err)        status = {1'b1, err_kind};
    else if (!mode) status = ST_PACKET;
    else if (first) status = ST_FIRST;
    else if (last)  status = ST_LAST;
    else            status = ST_MIDDLE;
    rec_want        = err || mode || last;
    rec_word.spare  = '0;
    rec_word.status = status;
    rec_word.rst_bit = 1'b0;
    rec_word.pri_bit = 1'b0;
    rec_word.chan   = 8'(chan);
    rec_word.offset = mode ? offset : pkt_off;
  end

  // R3
  buf_mode_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode && !err) |-> (rec_want && status != ST_PACKET && !status[2]));
endmodule

// File: rtl/txdq_fifo.sv
module txdq_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             head_valid,
  input  logic             head_take,
  output logic [WIDTH-1:0] head_data,
  output logic [CNTW-1:0]  count,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign do_push    = push && !flush;
  assign do_pop     = head_valid && head_take && !flush;
  assign head_valid = (count != '0);
  assign full       = (count == CNTW'(DEPTH));
  assign head_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      count <= count + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |-> (count < CNTW'(DEPTH)));
  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !head_valid);
  // R10
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !head_take && !flush) |=> $stable(head_data));
endmodule

// File: rtl/txdq_thresh.sv
module txdq_thresh #(
  parameter int CNTW = 5,
  parameter int THW  = 3
) (
  input  logic [CNTW-1:0] count,
  input  logic [THW-1:0]  level,
  output logic            hit
);
  logic [CNTW-1:0] limit;
  assign limit = CNTW'(level) + CNTW'(1);
  assign hit   = (count >= limit);
endmodule

// File: rtl/txdq_writer.sv
module txdq_writer
  import txdq_pkg::*;
#(
  parameter int CHW   = 8,
  parameter int DEPTH = 16,
  parameter int THW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  output logic                 evt_ready,
  input  logic [CHW-1:0]       evt_chan,
  input  logic [15:0]          evt_offset,
  input  logic                 evt_first,
  input  logic                 evt_last,
  input  logic                 evt_err,
  input  logic [1:0]           evt_err_kind,
  input  logic [(1<<CHW)-1:0]  chan_mode,
  input  logic                 q_enable,
  input  logic                 q_flush,
  input  logic [THW-1:0]       q_thresh,
  output logic                 rec_valid,
  input  logic                 rec_ready,
  output logic [31:0]          rec_data,
  output logic                 q_thresh_hit,
  output logic                 srl_abort_req,
  output logic [CHW-1:0]       srl_abort_chan,
  output logic                 cfg_clr_en,
  output logic [CHW-1:0]       cfg_clr_chan
);
  localparam int CNTW = $clog2(DEPTH) + 1;

  logic            acc, rec_want, q_full;
  txdq_rec_t       rec_word;
  logic [CNTW-1:0] q_count;

  assign evt_ready = !q_flush && (!q_enable || !q_full);
  assign acc       = evt_valid && evt_ready;

  txdq_rec_builder #(.CHW(CHW)) u_build (
    .clk(clk), .rst_n(rst_n), .acc(acc), .chan(evt_chan), .offset(evt_offset),
    .first(evt_first), .last(evt_last), .err(evt_err), .err_kind(evt_err_kind),
    .chan_mode(chan_mode), .rec_want(rec_want), .rec_word(rec_word)
  );

  txdq_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(q_flush),
    .push(acc && rec_want && q_enable), .push_data(rec_word),
    .head_valid(rec_valid), .head_take(rec_ready), .head_data(rec_data),
    .count(q_count), .full(q_full)
  );

  txdq_thresh #(.CNTW(CNTW), .THW(THW)) u_thr (
    .count(q_count), .level(q_thresh), .hit(q_thresh_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srl_abort_req  <= 1'b0;
      srl_abort_chan <= '0;
      cfg_clr_en     <= 1'b0;
      cfg_clr_chan   <= '0;
    end else begin
      srl_abort_req <= acc && evt_err;
      cfg_clr_en    <= acc && evt_err;
      if (acc && evt_err) begin
        srl_abort_chan <= evt_chan;
        cfg_clr_chan   <= evt_chan;
      end
    end
  end

  // R4
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srl_abort_req |-> $past(evt_valid && evt_ready && evt_err));
  // R4
  abort_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srl_abort_req |-> (cfg_clr_en && cfg_clr_chan == srl_abort_chan));
  // R9
  off_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !q_enable && !rec_ready) |=> (q_count <= $past(q_count)));
  // R7
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |-> !evt_ready);
endmodule

// File: tb/txdq_writer_test.sv
module txdq_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0, evt_ready;
  logic [7:0]  evt_chan = '0;
  logic [15:0] evt_offset = '0;
  logic        evt_first = 1'b0, evt_last = 1'b0, evt_err = 1'b0;
  logic [1:0]  evt_err_kind = '0;
  logic [255:0] chan_mode = '0;
  logic        q_enable = 1'b1, q_flush = 1'b0;
  logic [2:0]  q_thresh = '0;
  logic        rec_valid, rec_ready = 1'b1;
  logic [31:0] rec_data;
  logic        q_thresh_hit, srl_abort_req, cfg_clr_en;
  logic [7:0]  srl_abort_chan, cfg_clr_chan;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  txdq_writer uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_chan(evt_chan), .evt_offset(evt_offset), .evt_first(evt_first),
    .evt_last(evt_last), .evt_err(evt_err), .evt_err_kind(evt_err_kind),
    .chan_mode(chan_mode), .q_enable(q_enable), .q_flush(q_flush),
    .q_thresh(q_thresh), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_data(rec_data), .q_thresh_hit(q_thresh_hit),
    .srl_abort_req(srl_abort_req), .srl_abort_chan(srl_abort_chan),
    .cfg_clr_en(cfg_clr_en), .cfg_clr_chan(cfg_clr_chan)
  );

  function automatic logic [31:0] mkrec(logic [7:0] ch, logic [2:0] st, logic [15:0] off);
    return {3'b000, st, 2'b00, ch, off};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // fields: chan8 mode first last err kind2 off16 | push status3 expoff16
  localparam int NV = 15;
  localparam logic [49:0] TBL [NV] = '{
    {8'd3,   1'b0,1'b1,1'b0,1'b0,2'd0,16'h0100, 1'b0,3'd0,16'h0000}, // R2 first, no record
    {8'd3,   1'b0,1'b0,1'b0,1'b0,2'd0,16'h0110, 1'b0,3'd0,16'h0000}, // R2 middle
    {8'd3,   1'b0,1'b0,1'b1,1'b0,2'd0,16'h0120, 1'b1,3'd0,16'h0100}, // R2 last
    {8'd5,   1'b0,1'b1,1'b1,1'b0,2'd0,16'h0200, 1'b1,3'd0,16'h0200}, // R2 single
    {8'd9,   1'b1,1'b1,1'b0,1'b0,2'd0,16'h0300, 1'b1,3'd1,16'h0300}, // R3 first
    {8'd9,   1'b1,1'b0,1'b0,1'b0,2'd0,16'h0310, 1'b1,3'd2,16'h0310}, // R3 middle
    {8'd9,   1'b1,1'b0,1'b1,1'b0,2'd0,16'h0320, 1'b1,3'd3,16'h0320}, // R3 last
    {8'd10,  1'b1,1'b1,1'b1,1'b0,2'd0,16'h0400, 1'b1,3'd1,16'h0400}, // R3 single
    {8'd255, 1'b0,1'b1,1'b0,1'b0,2'd0,16'hABCD, 1'b0,3'd0,16'h0000}, // R1 top channel
    {8'd255, 1'b0,1'b0,1'b0,1'b1,2'd2,16'hABD0, 1'b1,3'd6,16'hABCD}, // R5 R4 error mode0
    {8'd0,   1'b1,1'b1,1'b0,1'b1,2'd0,16'h0001, 1'b1,3'd4,16'h0001}, // R5 R4 error mode1
    {8'd3,   1'b0,1'b1,1'b0,1'b0,2'd0,16'h0500, 1'b0,3'd0,16'h0000}, // R2 reopen
    {8'd4,   1'b1,1'b0,1'b0,1'b0,2'd0,16'h0600, 1'b1,3'd2,16'h0600}, // R3 interleave
    {8'd3,   1'b0,1'b0,1'b1,1'b0,2'd0,16'h0510, 1'b1,3'd0,16'h0500}, // R2 interleaved
    {8'd7,   1'b1,1'b0,1'b1,1'b1,2'd3,16'h0700, 1'b1,3'd7,16'h0700}  // R4 kind 3
  };

  task automatic send(logic [7:0] ch, logic md, logic f, logic l, logic e,
                      logic [1:0] k, logic [15:0] off);
    chan_mode[ch] = md;
    evt_chan = ch; evt_offset = off; evt_first = f; evt_last = l;
    evt_err = e; evt_err_kind = k; evt_valid = 1'b1;
    @(posedge clk); #1;
    evt_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset rec_valid", 32'(rec_valid), 32'd0);
    chk("R6 reset evt_ready", 32'(evt_ready), 32'd1);
    chk("R8 reset thresh", 32'(q_thresh_hit), 32'd0);
    chk("R4 reset abort", 32'(srl_abort_req), 32'd0);
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = TBL[i];
      send(v[49:42], v[41], v[40], v[39], v[38], v[37:36], v[35:20]);
      @(negedge clk);
      chk("R2 R3 record present", 32'(rec_valid), 32'(v[19]));
      if (v[19]) chk("R1 R2 R3 R5 record word", rec_data, mkrec(v[49:42], v[18:16], v[15:0]));
      chk("R4 abort pulse", 32'(srl_abort_req), 32'(v[38]));
      chk("R4 disable pulse", 32'(cfg_clr_en), 32'(v[38]));
      if (v[38]) begin
        chk("R4 abort chan", 32'(srl_abort_chan), 32'(v[49:42]));
        chk("R4 disable chan", 32'(cfg_clr_chan), 32'(v[49:42]));
      end
      @(posedge clk); #1;
    end
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(srl_abort_req), 32'd0);

    // fill with threshold 3
    @(posedge clk); #1;
    rec_ready = 1'b0;
    q_thresh = 3'd3;
    for (int i = 0; i < 16; i++) begin
      send(8'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 16'(i));
      @(negedge clk);
      chk("R8 threshold flag", 32'(q_thresh_hit), 32'(i + 1 >= 4));
      @(posedge clk); #1;
    end
    chk("R6 full blocks", 32'(evt_ready), 32'd0);
    chan_mode[1] = 1'b1;
    evt_chan = 8'd1; evt_offset = 16'h00FF; evt_first = 1'b1; evt_last = 1'b0;
    evt_err = 1'b0; evt_valid = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 still blocked", 32'(evt_ready), 32'd0);
    chk("R10 head held", rec_data, mkrec(8'd1, 3'd1, 16'h0000));
    rec_ready = 1'b1;
    @(posedge clk); #1;
    rec_ready = 1'b0;
    @(negedge clk);
    chk("R6 order after pop", rec_data, mkrec(8'd1, 3'd1, 16'h0001));
    chk("R6 space reopens", 32'(evt_ready), 32'd1);
    @(posedge clk); #1;
    evt_valid = 1'b0;
    @(negedge clk);
    chk("R6 refilled", 32'(evt_ready), 32'd0);

    // flush
    @(posedge clk); #1;
    q_flush = 1'b1;
    @(negedge clk);
    chk("R7 ready low during flush", 32'(evt_ready), 32'd0);
    @(posedge clk); #1;
    q_flush = 1'b0;
    @(negedge clk);
    chk("R7 flushed empty", 32'(rec_valid), 32'd0);
    chk("R8 flag after flush", 32'(q_thresh_hit), 32'd0);
    q_thresh = 3'd0;

    // queue disabled
    @(posedge clk); #1;
    q_enable = 1'b0;
    send(8'd2, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 16'h0042);
    @(negedge clk);
    chk("R9 no record while disabled", 32'(rec_valid), 32'd0);
    chk("R9 abort while disabled", 32'(srl_abort_req), 32'd1);
    chk("R9 disable chan", 32'(cfg_clr_chan), 32'd2);
    @(posedge clk); #1;
    q_enable = 1'b1;
    rec_ready = 1'b1;
    send(8'd2, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0043);
    @(negedge clk);
    chk("R9 re-enabled record", rec_data, mkrec(8'd2, 3'd3, 16'h0043));
    chk("R8 flag at one entry", 32'(q_thresh_hit), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule